// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block keeps a running credit for a vending machine. Coins arrive one at a time over a small valid/ready stream, each carrying an 8-bit value. The block adds each accepted coin to an internal 8-bit credit register. When the credit is at least the 8-bit price on the `price` pin, it raises `dispense` for one cycle and clears the credit for the next customer.

Control is a four-state Moore machine. The states are reset, idle-waiting, accumulate and vend, with binary codes 00, 01, 10 and 11. A datapath next to it holds the credit, a captured copy of the last coin, a saturating adder and a below-price comparator. The credit saturates at 255 and never wraps, so a large deposit cannot look smaller than the price.

Back-pressure rules: `coin_ready` is high only while the machine waits for a coin. A coin is transferred on a cycle where `coin_valid` and `coin_ready` are both high. The value is sampled in that cycle, so the source may change or drop it afterwards. While `coin_ready` is low, `coin_valid` and `coin_value` are ignored. The source must not expect its coin to be taken then, and it keeps the coin until a transfer cycle.

Top module: `vend_unit`

## Requirements
- R1: A synchronous active-high `rst` holds `dispense` and `coin_ready` low during reset and for the first cycle after release. `coin_ready` rises on the second cycle after release.
- R2: A coin is transferred only on a cycle with `coin_valid` and `coin_ready` both high. In the following cycle `coin_ready` is low, and `coin_valid` is ignored.
- R3: Each transferred coin adds its value to the credit exactly once, saturating at 255. For example, 200 then 100 gives 255, not 44.
- R4: While waiting with no coin offered, a credit not below `price` raises `dispense` in the next cycle. A credit below `price` keeps the block waiting with `coin_ready` high. With `price` 0, a vend follows directly after reset.
- R5: A coin offered while waiting takes priority over the vend decision in that cycle. The coin is added first, and the vend is then decided on the new credit.
- R6: `dispense` is high for exactly one cycle. It is followed by one cycle with `coin_ready` low, during which the credit is cleared. After that the block waits again with zero credit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| coin_valid | input | 1 | A coin is offered on `coin_value` |
| coin_ready | output | 1 | Block can take a coin this cycle |
| coin_value | input | 8 | Value of the offered coin |
| price | input | 8 | Item price, compared against the credit |
| dispense | output | 1 | One-cycle vend pulse |

## Verification
A credit register that adds wrongly, wraps instead of saturating, or is not cleared shows up as a missing, early or extra `dispense` pulse. This is visible within two cycles of the coin that should have decided it. A controller state that is wrong shows at once on `coin_ready` or `dispense`, because both are decoded directly from the state. The directed tests therefore pin each vend to its exact cycle and watch `coin_ready` on every cycle around each transfer.

// File: rtl/vend_pkg.sv
package vend_pkg;
  localparam int unsigned VAL_W = 8;

  typedef enum logic [1:0] {
    ST_RESET = 2'b00,
    ST_IDLE  = 2'b01,
    ST_ACCUM = 2'b10,
    ST_VEND  = 2'b11
  } vend_state_t;
endpackage

// File: rtl/vend_credit.sv
module vend_credit #(
  parameter int unsigned W = vend_pkg::VAL_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         take_coin,
  input  logic [W-1:0] coin_value,
  input  logic         credit_clr,
  input  logic         credit_ld,
  input  logic [W-1:0] price,
  output logic         below_price,
  output logic [W-1:0] credit
);
  localparam logic [W-1:0] SAT_MAX = '1;

  logic [W-1:0] coin_q;
  logic [W:0]   sum_wide;
  logic [W-1:0] sum_sat;

  always_ff @(posedge clk) begin
    if (rst)            coin_q <= '0;
    else if (take_coin) coin_q <= coin_value;
  end

  always_comb begin
    sum_wide = {1'b0, credit} + {1'b0, coin_q};
    sum_sat  = sum_wide[W] ? SAT_MAX : sum_wide[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || credit_clr) credit <= '0;
    else if (credit_ld)    credit <= sum_sat;
  end

  assign below_price = credit < price;
endmodule

// File: rtl/vend_fsm.sv
module vend_fsm
  import vend_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        coin_valid,
  input  logic        below_price,
  output logic        coin_ready,
  output logic        take_coin,
  output logic        credit_clr,
  output logic        credit_ld,
  output logic        dispense,
  output vend_state_t state
);
  vend_state_t state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_RESET: state_nx = ST_IDLE;
      ST_IDLE: begin
        if (coin_valid)        state_nx = ST_ACCUM;
        else if (!below_price) state_nx = ST_VEND;
      end
      ST_ACCUM: state_nx = ST_IDLE;
      ST_VEND:  state_nx = ST_RESET;
      default:  state_nx = ST_RESET;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_RESET;
    else     state <= state_nx;
  end

  assign coin_ready = (state == ST_IDLE);
  assign take_coin  = coin_ready && coin_valid;
  assign credit_clr = (state == ST_RESET);
  assign credit_ld  = (state == ST_ACCUM);
  assign dispense   = (state == ST_VEND);
endmodule

// File: rtl/vend_unit.sv
module vend_unit
  import vend_pkg::*;
#(
  parameter int unsigned W = VAL_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         coin_valid,
  output logic         coin_ready,
  input  logic [W-1:0] coin_value,
  input  logic [W-1:0] price,
  output logic         dispense
);
  logic        take_coin;
  logic        credit_clr;
  logic        credit_ld;
  logic        below_price;
  logic [W-1:0] credit;
  vend_state_t state;

  vend_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .coin_valid (coin_valid),
    .below_price(below_price),
    .coin_ready (coin_ready),
    .take_coin  (take_coin),
    .credit_clr (credit_clr),
    .credit_ld  (credit_ld),
    .dispense   (dispense),
    .state      (state)
  );

  vend_credit #(.W(W)) u_credit (
    .clk        (clk),
    .rst        (rst),
    .take_coin  (take_coin),
    .coin_value (coin_value),
    .credit_clr (credit_clr),
    .credit_ld  (credit_ld),
    .price      (price),
    .below_price(below_price),
    .credit     (credit)
  );
endmodule

// File: rtl/vend_unit_chk.sv
module vend_unit_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         coin_valid,
  input logic         coin_ready,
  input logic [W-1:0] coin_value,
  input logic [W-1:0] price,
  input logic         dispense,
  input logic [W-1:0] credit
);
  function automatic logic [W-1:0] sat_add(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[W] ? {W{1'b1}} : s[W-1:0];
  endfunction

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!dispense && !coin_ready));

  p_ready_drops_r2: assert property (@(posedge clk) disable iff (rst)
    (coin_valid && coin_ready) |=> !coin_ready);

  p_sat_sum_r3: assert property (@(posedge clk) disable iff (rst)
    (coin_valid && coin_ready) |=> ##1
      (credit == sat_add($past(credit, 1), $past(coin_value, 2))));

  p_vend_when_paid_r4: assert property (@(posedge clk) disable iff (rst)
    (coin_ready && !coin_valid && (credit >= price)) |=> dispense);

  p_wait_when_short_r4: assert property (@(posedge clk) disable iff (rst)
    (coin_ready && !coin_valid && (credit < price)) |=> coin_ready);

  p_coin_first_r5: assert property (@(posedge clk) disable iff (rst)
    (coin_valid && coin_ready) |=> !dispense);

  p_one_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    dispense |=> (!dispense && !coin_ready));

  p_cleared_after_r6: assert property (@(posedge clk) disable iff (rst)
    dispense |=> ##1 (coin_ready && (credit == '0)));
endmodule

bind vend_unit vend_unit_chk #(.W(W)) u_vend_unit_chk (
  .clk        (clk),
  .rst        (rst),
  .coin_valid (coin_valid),
  .coin_ready (coin_ready),
  .coin_value (coin_value),
  .price      (price),
  .dispense   (dispense),
  .credit     (credit)
);

// File: tb/test_vend_unit.sv
`timescale 1ns/1ps
module test_vend_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       coin_valid = 1'b0;
  logic [7:0] coin_value = '0;
  logic [7:0] price = 8'd50;
  logic       coin_ready;
  logic       dispense;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vend_unit i_vend_unit (
    .clk       (clk),
    .rst       (rst),
    .coin_valid(coin_valid),
    .coin_ready(coin_ready),
    .coin_value(coin_value),
    .price     (price),
    .dispense  (dispense)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reset, release, and return once waiting (ready high).
  task automatic restart(input logic [7:0] p);
    coin_valid = 1'b0;
    price = p;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // Offer a coin for one transfer; returns at the negedge in the accumulate cycle.
  task automatic coin(input logic [7:0] v);
    while (!coin_ready) @(negedge clk);
    coin_valid = 1'b1;
    coin_value = v;
    @(negedge clk);
    coin_valid = 1'b0;
    coin_value = 8'hA5;
    check("R2 ready low after transfer", coin_ready, 0);
  endtask

  task automatic t_reset();
    coin_valid = 1'b0;
    price = 8'd50;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 dispense in reset", dispense, 0);
    check("R1 ready in reset", coin_ready, 0);
    rst = 1'b0;
    check("R1 ready first cycle after release", coin_ready, 0);
    check("R1 dispense first cycle after release", dispense, 0);
    @(negedge clk);
    check("R1 ready second cycle", coin_ready, 1);
  endtask

  task automatic t_exact_price();
    restart(8'd50);
    coin(8'd25);
    @(negedge clk);
    @(negedge clk);
    check("R4 no vend below price", dispense, 0);
    check("R4 still waiting", coin_ready, 1);
    coin(8'd25);
    @(negedge clk);
    check("R4 not yet vending", dispense, 0);
    @(negedge clk);
    check("R4 vend at exact price", dispense, 1);
    @(negedge clk);
    check("R6 pulse one cycle", dispense, 0);
    check("R6 ready low after vend", coin_ready, 0);
    @(negedge clk);
    check("R6 waiting again", coin_ready, 1);
  endtask

  task automatic t_overshoot();
    restart(8'd30);
    coin(8'd20);
    coin(8'd20);
    @(negedge clk);
    @(negedge clk);
    check("R4 vend on overshoot", dispense, 1);
  endtask

  task automatic t_below();
    restart(8'd100);
    coin(8'd40);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R4 no vend below price", dispense, 0);
      check("R4 ready while short", coin_ready, 1);
    end
  endtask

  task automatic t_saturate();
    restart(8'd255);
    coin(8'd200);
    coin(8'd100);
    @(negedge clk);
    @(negedge clk);
    check("R3 saturated credit vends at 255", dispense, 1);
  endtask

  task automatic t_cleared();
    restart(8'd50);
    coin(8'd30);
    coin(8'd30);
    @(negedge clk);
    @(negedge clk);
    check("R6 first vend", dispense, 1);
    coin(8'd30);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R6 credit cleared, no second vend", dispense, 0);
    end
  endtask

  task automatic t_priority();
    restart(8'd100);
    coin(8'd40);
    @(negedge clk);
    price = 8'd40;
    coin_valid = 1'b1;
    coin_value = 8'd10;
    @(negedge clk);
    coin_valid = 1'b0;
    check("R5 coin beats vend", dispense, 0);
    check("R5 accumulating", coin_ready, 0);
    @(negedge clk);
    check("R5 deciding on new credit", dispense, 0);
    @(negedge clk);
    check("R5 vend after add", dispense, 1);
  endtask

  task automatic t_held_valid();
    restart(8'd30);
    coin_valid = 1'b1;
    coin_value = 8'd20;
    @(negedge clk);
    check("R2 ready low while valid held", coin_ready, 0);
    @(negedge clk);
    coin_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R2 held coin counted once", dispense, 0);
    end
    coin(8'd20);
    @(negedge clk);
    @(negedge clk);
    check("R2 second coin completes price", dispense, 1);
  endtask

  task automatic t_zero_price();
    coin_valid = 1'b0;
    price = 8'd0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R4 zero price waiting", dispense, 0);
    @(negedge clk);
    check("R4 zero price vends", dispense, 1);
  endtask

  initial begin
    t_reset();
    t_exact_price();
    t_overshoot();
    t_below();
    t_saturate();
    t_cleared();
    t_priority();
    t_held_valid();
    t_zero_price();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule